// File: doc/BRIEF.md
# Self-Checking FIR Filter with Predictive Error Substitution

This block is a direct-form FIR filter whose arithmetic may now and then produce a large wrong result, for example when its supply is lowered below the point where every path meets timing. A small checker runs beside the filter. It estimates the present output from the outputs already delivered. Whenever the filter's result strays too far from that estimate, the estimate goes out in its place and a flag is raised for that sample.

Two estimators are available at run time. The linear predictor extrapolates from the last two delivered outputs and suits signals with moderate correlation. The difference estimator reuses the last delivered output and suits strongly correlated signals. The history that feeds both estimators holds the corrected outputs only, so a caught error cannot reach later estimates. A mask input is XORed onto the filter result before checking. A testbench uses it to imitate datapath faults.

Top module: `ant_filter`

## Requirements
- R1: A sample presented with `in_valid` high produces `out_valid` high on the following clock edge. A cycle without `in_valid` gives `out_valid` low on the following edge.
- R2: With no flag raised, `out_data` is the filter sum of the current and three previous valid inputs, with weights 9, 6, 3 and 2 from newest to oldest, saturated and then XORed with `inj_mask`.
- R3: The filter sum saturates to the signed 16-bit range, giving 32767 or -32768 and never a wrapped value.
- R4: The flag is raised when the absolute difference between the checked result and the estimate is strictly greater than `thresh`. A difference equal to `thresh` raises no flag.
- R5: When the flag is raised, `out_data` equals the estimate rather than the checked result.
- R6: With `mode` = 0 (prediction), the estimate is 2·y1 − y2, saturated to 16 bits, where y1 and y2 are the two most recent delivered outputs.
- R7: With `mode` = 1 (difference), the estimate is y1, the most recent delivered output.
- R8: The estimate history is loaded with the delivered (corrected) output, never with the raw checked result.
- R9: After reset, `out_valid`, `out_flag` and `out_data` are zero, and the input delay line and the estimate history hold zeros.
- R10: A cycle without `in_valid` leaves `out_data`, `out_flag`, the delay line and the estimate history unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_data` as a new sample |
| in_data | input | 12 | Signed input sample |
| mode | input | 1 | 0: two-tap prediction, 1: previous-output estimate |
| thresh | input | 16 | Unsigned detection threshold |
| inj_mask | input | 16 | XOR mask applied to the filter result before checking |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_data | output | 16 | Signed corrected sample |
| out_flag | output | 1 | Set when the sample was replaced by the estimate |

## Verification
The clocked properties assume that `in_valid` stays low for the whole of reset. If it did not, the latency check would have nothing to measure against at the first edge after release. The bench holds `in_valid` low until reset is released. It changes all inputs only on falling edges, so each rising edge sees stable values. Idle cycles are allowed to carry arbitrary data and mask values, because the hold property only assumes that `in_valid` is low.

// File: rtl/ant_pkg.sv
`timescale 1ns/1ps
package ant_pkg;

    typedef enum logic {
        ANT_PREDICT = 1'b0,
        ANT_DIFFER  = 1'b1
    } ant_mode_e;

endpackage

// File: rtl/ant_fir_core.sv
`timescale 1ns/1ps
module ant_fir_core #(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 16,
    parameter int TAPS   = 4,
    parameter int COEF_W = 8,
    parameter int H [TAPS] = '{9, 6, 3, 2}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_data,
    output logic signed [OUT_W-1:0] main_out
);
    localparam int ACC_W = IN_W + COEF_W + $clog2(TAPS) + 1;
    localparam logic signed [ACC_W-1:0] HI = ACC_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] LO = ACC_W'(-(2 ** (OUT_W - 1)));

    typedef struct packed {
        logic [TAPS-1:1][IN_W-1:0] dly;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [TAPS-1:0][IN_W-1:0] tap;
    logic signed [ACC_W-1:0]   prod [TAPS];
    logic signed [ACC_W-1:0]   acc;

    assign tap[0] = in_data;

    for (genvar k = 1; k < TAPS; k++) begin : g_tap
        assign tap[k] = st_q.dly[k];
    end

    for (genvar k = 0; k < TAPS; k++) begin : g_mul
        assign prod[k] = ACC_W'($signed(tap[k])) * ACC_W'(H[k]);
    end

    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + prod[k];
        end
        if (acc > HI) begin
            main_out = HI[OUT_W-1:0];
        end else if (acc < LO) begin
            main_out = LO[OUT_W-1:0];
        end else begin
            main_out = acc[OUT_W-1:0];
        end
    end

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.dly[1] = in_data;
            for (int k = 2; k < TAPS; k++) begin
                st_d.dly[k] = st_q.dly[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R10: the delay line moves only on a valid sample
    assert_dly_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(st_q));

endmodule

// File: rtl/ant_estimator.sv
`timescale 1ns/1ps
module ant_estimator
    import ant_pkg::*;
#(
    parameter int OUT_W = 16,
    parameter int PC1   = 2,
    parameter int PC2   = -1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [OUT_W-1:0] corr_in,
    input  ant_mode_e               mode,
    output logic signed [OUT_W-1:0] est_out,
    output logic signed [OUT_W-1:0] last_out
);
    localparam int PW = OUT_W + 4;
    localparam logic signed [PW-1:0] HI = PW'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [PW-1:0] LO = PW'(-(2 ** (OUT_W - 1)));

    typedef struct packed {
        logic signed [OUT_W-1:0] y1;
        logic signed [OUT_W-1:0] y2;
    } hist_t;

    hist_t h_d, h_q;
    logic signed [PW-1:0]    lin;
    logic signed [OUT_W-1:0] pred;

    always_comb begin
        lin = PW'(h_q.y1) * PW'(PC1) + PW'(h_q.y2) * PW'(PC2);
        if (lin > HI) begin
            pred = HI[OUT_W-1:0];
        end else if (lin < LO) begin
            pred = LO[OUT_W-1:0];
        end else begin
            pred = lin[OUT_W-1:0];
        end
        est_out = (mode == ANT_DIFFER) ? h_q.y1 : pred;
    end

    assign last_out = h_q.y1;

    always_comb begin
        h_d = h_q;
        if (upd) begin
            h_d.y1 = corr_in;
            h_d.y2 = h_q.y1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

endmodule

// File: rtl/ant_filter.sv
`timescale 1ns/1ps
module ant_filter
    import ant_pkg::*;
#(
    parameter int IN_W   = 12,
    parameter int OUT_W  = 16,
    parameter int TAPS   = 4,
    parameter int COEF_W = 8,
    parameter int H [TAPS] = '{9, 6, 3, 2},
    parameter int PC1    = 2,
    parameter int PC2    = -1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [IN_W-1:0]         in_data,
    input  logic                    mode,
    input  logic [OUT_W-1:0]        thresh,
    input  logic [OUT_W-1:0]        inj_mask,
    output logic                    out_valid,
    output logic [OUT_W-1:0]        out_data,
    output logic                    out_flag
);
    typedef struct packed {
        logic                    vld;
        logic                    flag;
        logic signed [OUT_W-1:0] data;
    } out_st_t;

    out_st_t s_d, s_q;

    logic signed [OUT_W-1:0] main_v;
    logic signed [OUT_W-1:0] chk_v;
    logic signed [OUT_W-1:0] est_v;
    logic signed [OUT_W-1:0] hist_last;
    logic signed [OUT_W-1:0] corr_v;
    logic signed [OUT_W:0]   dif;
    logic        [OUT_W:0]   mag;
    logic                    hit;

    ant_fir_core #(
        .IN_W(IN_W), .OUT_W(OUT_W), .TAPS(TAPS), .COEF_W(COEF_W), .H(H)
    ) i_core (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_data(in_data), .main_out(main_v)
    );

    ant_estimator #(
        .OUT_W(OUT_W), .PC1(PC1), .PC2(PC2)
    ) i_est (
        .clk(clk), .rst_n(rst_n), .upd(in_valid), .corr_in(corr_v),
        .mode(ant_mode_e'(mode)), .est_out(est_v), .last_out(hist_last)
    );

    always_comb begin
        chk_v  = main_v ^ inj_mask;
        dif    = {chk_v[OUT_W-1], chk_v} - {est_v[OUT_W-1], est_v};
        mag    = dif[OUT_W] ? (~dif + 1'b1) : dif;
        hit    = mag > {1'b0, thresh};
        corr_v = hit ? est_v : chk_v;

        s_d     = s_q;
        s_d.vld = in_valid;
        if (in_valid) begin
            s_d.flag = hit;
            s_d.data = corr_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_valid = s_q.vld;
    assign out_flag  = s_q.flag;
    assign out_data  = s_q.data;

    assert_lat_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_lat_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_flag)));

    // R5: a flagged sample leaves with the estimator's value
    assert_subst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && hit) |=> (out_flag && out_data == $past(est_v)));

    // R8: the history register and the output register agree after every sample
    assert_hist_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (hist_last == out_data));

endmodule

// File: tb/test_ant_filter.sv
`timescale 1ns/1ps
module test_ant_filter;

    typedef struct packed {
        logic [11:0] x;
        logic        m;
        logic [15:0] thr;
        logic [15:0] mask;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VTAB [NV] = '{
        '{12'd100,  1'b0, 16'hFFFF, 16'h0000},
        '{12'd200,  1'b0, 16'hFFFF, 16'h0000},
        '{12'd300,  1'b0, 16'hFFFF, 16'h0000},
        '{12'd400,  1'b0, 16'hFFFF, 16'h0000},
        '{12'd500,  1'b0, 16'd40,   16'h0000},
        '{12'd600,  1'b0, 16'd40,   16'h4000},
        '{12'd700,  1'b0, 16'd40,   16'h0000},
        '{12'hED4,  1'b0, 16'hFFFF, 16'h0000},
        '{12'hED4,  1'b1, 16'hFFFF, 16'h0000},
        '{12'hED4,  1'b1, 16'd10,   16'h0800},
        '{12'hED4,  1'b1, 16'd10,   16'h0001},
        '{12'd50,   1'b1, 16'd0,    16'h0000},
        '{12'd1000, 1'b0, 16'd100,  16'h8000},
        '{12'h830,  1'b0, 16'hFFFF, 16'h0000},
        '{12'd2047, 1'b1, 16'd500,  16'h0100},
        '{12'd0,    1'b0, 16'hFFFF, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        mode = 1'b0;
    logic [15:0] thresh = '0;
    logic [15:0] inj_mask = '0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int mx0, mx1, mx2;
    int my1, my2;

    always #2.5 clk = ~clk;

    ant_filter i_ant_filter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .mode(mode), .thresh(thresh), .inj_mask(inj_mask),
        .out_valid(out_valid), .out_data(out_data), .out_flag(out_flag)
    );

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int s12(input logic [11:0] v);
        return int'($signed(v));
    endfunction

    function automatic int s16(input logic [15:0] v);
        return int'($signed(v));
    endfunction

    // model: checked value, estimate and magnitude for the next sample
    function automatic void mdl_eval(input logic [11:0] x, input logic m,
                                     input logic [15:0] mask,
                                     output int chk, output int est, output int mag);
        int mn;
        logic [15:0] t;
        mn  = sat16(9 * s12(x) + 6 * mx0 + 3 * mx1 + 2 * mx2);
        t   = 16'(mn) ^ mask;
        chk = s16(t);
        est = m ? my1 : sat16(2 * my1 - my2);
        mag = (chk > est) ? chk - est : est - chk;
    endfunction

    task automatic mdl_reset();
        mx0 = 0; mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdl_reset();
    endtask

    // apply one valid sample at a falling edge, check at the next falling edge
    task automatic apply(input logic [11:0] x, input logic m, input logic [15:0] thr,
                         input logic [15:0] mask, input string req);
        int chk, est, mag, eout;
        bit ef;
        mdl_eval(x, m, mask, chk, est, mag);
        ef   = mag > int'(thr);
        eout = ef ? est : chk;
        in_valid = 1'b1; in_data = x; mode = m; thresh = thr; inj_mask = mask;
        @(negedge clk);
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " flag"}, int'(out_flag), int'(ef));
        check({req, " data"}, s16(out_data), eout);
        mx2 = mx1; mx1 = mx0; mx0 = s12(x);
        my2 = my1; my1 = eout;
        in_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int c, e, mg, prev;
        mdl_reset();
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 out_valid", int'(out_valid), 0);
        check("R9 out_flag", int'(out_flag), 0);
        check("R9 out_data", s16(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle out_valid", int'(out_valid), 0);

        // table walk: R2, R5, R6, R7 depending on the vector
        for (int i = 0; i < NV; i++) begin
            string rq;
            mdl_eval(VTAB[i].x, VTAB[i].m, VTAB[i].mask, c, e, mg);
            if (mg > int'(VTAB[i].thr)) rq = "R5";
            else if (VTAB[i].mask != 0) rq = "R2";
            else rq = VTAB[i].m ? "R7" : "R6";
            apply(VTAB[i].x, VTAB[i].m, VTAB[i].thr, VTAB[i].mask, rq);
        end

        // R10: idle cycles with busy inputs change nothing
        prev = s16(out_data);
        for (int i = 0; i < 3; i++) begin
            in_valid = 1'b0; in_data = 12'h7FF; inj_mask = 16'hFFFF; thresh = 16'd0;
            @(negedge clk);
            check("R1 no valid", int'(out_valid), 0);
            check("R10 data hold", s16(out_data), prev);
        end
        apply(12'd10, 1'b0, 16'hFFFF, 16'h0000, "R10 history kept");

        // R3: saturation both ways
        do_reset();
        for (int i = 0; i < 4; i++) apply(12'd2047, 1'b0, 16'hFFFF, 16'h0000, "R3 high");
        check("R3 top clip", s16(out_data), 32767);
        for (int i = 0; i < 4; i++) apply(12'h800, 1'b0, 16'hFFFF, 16'h0000, "R3 low");
        check("R3 bottom clip", s16(out_data), -32768);

        // R4: equality is not an error, one below is
        do_reset();
        apply(12'd120, 1'b0, 16'hFFFF, 16'h0000, "R6 seed");
        apply(12'd130, 1'b0, 16'hFFFF, 16'h0000, "R6 seed");
        mdl_eval(12'd140, 1'b0, 16'h0400, c, e, mg);
        apply(12'd140, 1'b0, 16'(mg), 16'h0400, "R4 equal");
        check("R4 equal no flag", int'(out_flag), 0);
        do_reset();
        apply(12'd120, 1'b0, 16'hFFFF, 16'h0000, "R6 seed");
        apply(12'd130, 1'b0, 16'hFFFF, 16'h0000, "R6 seed");
        apply(12'd140, 1'b0, 16'(mg - 1), 16'h0400, "R4 above");
        check("R4 above flags", int'(out_flag), 1);
        check("R5 takes estimate", s16(out_data), e);

        // R8: next estimate is built from the corrected value
        prev = s16(out_data);
        apply(12'd150, 1'b1, 16'd0, 16'h4000, "R8 history");
        check("R8 equals previous corrected", s16(out_data), prev);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule